// File: doc/BRIEF.md
# Dot-Matrix Column Scan Controller

This block refreshes a four-character display made of 5x7 LED dot arrays. The display holds its row data in an internal serial chain of 28 bits, and has five external column-enable lines. Each enable line drives the same column in all four characters. The controller keeps one frame, five 28-bit column words, in a small RAM that the host writes through a plain write port. It then loops through the columns without stopping. For each column it fetches the word and shifts it into the display on a data line and a clock line. It then raises that column's enable for the rest of the slot.

Every column slot has a fixed length, derived from the system clock and set so that each column is refreshed at least 100 times per second. The shift-load time inside the slot is blanked: no enable is active while bits move, so the display never shows a half-loaded column. Brightness comes from an 8-bit level that pulse-width modulates the enable inside the on-window. The level is sampled once per slot. The column word is also captured once per slot, so a host write never tears a column that is being shifted.

Top module: `dmx_scan_ctrl`

## Requirements
- R1: While `rst` is high, `col_en` is all zero and `ser_clk` and `ser_data` are low. Host writes are accepted during reset.
- R2: Each slot shifts out the 28-bit word stored for its column, starting with bit 27 and ending with bit 0. Bits [7k+6:7k] belong to character k+1, with bit 7k+r lighting row r+1. Character four therefore leaves first and character one last. A 1 lights the LED.
- R3: Columns are scanned in the order 1, 2, 3, 4, 5 and then repeat, starting at column 1 after reset. `col_en[k]` enables column k+1, active high.
- R4: At most one bit of `col_en` is high in any cycle.
- R5: `col_en` is all zero while a column word is being shifted, including every cycle in which `ser_clk` is high.
- R6: Within a shift-load, `ser_clk` stays high for HALF cycles and low for HALF cycles, where HALF = ceil(CLK_HZ / (2 * min(SHIFT_HZ, 5 MHz))).
- R7: `ser_data` changes only while `ser_clk` is low. Before each rising edge of `ser_clk` it has been steady for at least HALF cycles, and it does not change while `ser_clk` is high.
- R8: A slot lasts SLOT = (CLK_HZ/1000) * min(SLOT_US, 2000) / 1000 cycles. The first slot starts on the first clock edge after reset is released, so the first rising edge of `ser_clk` follows HALF+2 edges later.
- R9: The on-window spans the last ON_LEN = SLOT - 2 - 56*HALF cycles of a slot. Within it, an 8-bit counter starts at 0 and increments every cycle, wrapping. The column is enabled in the cycles where the counter is below the level b. The enabled-cycle count per slot is therefore floor(ON_LEN/256)*b + min(ON_LEN mod 256, b).
- R10: A level of 255 keeps the column enabled for all ON_LEN cycles of the window.
- R11: A level of 0 keeps every column dark for the whole slot.
- R12: A write to the column being shifted does not change the bits of that load. The new word appears on the next visit to that column.
- R13: The level is sampled at the start of each slot. A change later in the slot does not affect that slot's enable count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Frame RAM write strobe |
| wr_col | input | 3 | Column index of the write (0 = column 1) |
| wr_rows | input | 28 | Row bits for that column, all four characters |
| bright | input | 8 | PWM brightness level |
| ser_data | output | 1 | Serial row data to the display chain |
| ser_clk | output | 1 | Serial shift clock to the display chain |
| col_en | output | 5 | Column enables, one-hot or zero |

## Verification
The bench builds the block with CLK_HZ = 125 MHz, SHIFT_HZ = 5 MHz and SLOT_US = 8. This gives an odd HALF of 13, which exercises the rounded-up divider, and 1000-cycle slots, so forty slots and eight full frames fit in a short run. The on-window is then 270 cycles, longer than the 256-step PWM period. Every level therefore tests the counter wrap: level 255 must give 270 enabled cycles and a mid level b must give b + min(14, b). Level 0, level 1, and the levels 14 and 15 around the wrap remainder are driven on purpose. Random writes go to idle columns, and two deliberate writes target the column whose shift is already under way.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  localparam int unsigned SHIFT_HZ_CAP = 5_000_000;
  localparam int unsigned SLOT_US_CAP  = 2000;

  // Slot phases as seen by the sequencer
  typedef enum logic [1:0] {
    PH_FETCH,
    PH_LOAD,
    PH_SHIFT,
    PH_ON
  } slot_phase_e;

  function automatic int unsigned shift_half_clks(input int unsigned clk_hz,
                                                  input int unsigned shift_hz);
    int unsigned eff;
    int unsigned half;
    eff  = (shift_hz > SHIFT_HZ_CAP) ? SHIFT_HZ_CAP : shift_hz;
    if (eff == 0) eff = 1;
    half = (clk_hz + 2 * eff - 1) / (2 * eff);
    return (half == 0) ? 1 : half;
  endfunction

  function automatic int unsigned slot_len_clks(input int unsigned clk_hz,
                                                input int unsigned slot_us);
    int unsigned us;
    us = (slot_us > SLOT_US_CAP) ? SLOT_US_CAP : slot_us;
    return (clk_hz / 1000) * us / 1000;
  endfunction

endpackage

// File: rtl/dmx_frame_mem.sv
module dmx_frame_mem #(
  parameter int DEPTH  = 5,
  parameter int WIDTH  = 28,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  // No reset on the array so that a block RAM can hold it.
  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) begin
      store[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= store[raddr];
    end
  end

endmodule

// File: rtl/dmx_row_shifter.sv
module dmx_row_shifter #(
  parameter int WIDTH = 28,
  parameter int HALF  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] word,
  output logic             ser_data,
  output logic             ser_clk,
  output logic             busy
);

  localparam int PH_W  = (2 * HALF > 1) ? $clog2(2 * HALF) : 1;
  localparam int BIT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0]  PH_END   = PH_W'(2 * HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WIDTH - 1);

  logic [WIDTH-1:0] sreg;
  logic [PH_W-1:0]  ph;
  logic [BIT_W-1:0] bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '0;
      ph       <= '0;
      bit_idx  <= '0;
      busy     <= 1'b0;
      ser_data <= 1'b0;
      ser_clk  <= 1'b0;
    end else if (load) begin
      sreg     <= word;
      ph       <= '0;
      bit_idx  <= '0;
      busy     <= 1'b1;
      ser_data <= word[WIDTH-1];
      ser_clk  <= 1'b0;
    end else if (busy) begin
      if (ph == PH_RISE) begin
        ser_clk <= 1'b1;
      end
      if (ph == PH_END) begin
        ph      <= '0;
        ser_clk <= 1'b0;
        sreg    <= {sreg[WIDTH-2:0], 1'b0};
        if (bit_idx == BIT_LAST) begin
          busy     <= 1'b0;
          ser_data <= 1'b0;
        end else begin
          bit_idx  <= bit_idx + 1'b1;
          ser_data <= sreg[WIDTH-2];
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dmx_pwm_gate.sv
module dmx_pwm_gate #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [PW-1:0] level,
  output logic          gate
);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Full scale means steady on; otherwise compare against the ramp.
  assign gate = (&level) | (cnt < level);

endmodule

// File: rtl/dmx_scan_ctrl.sv
module dmx_scan_ctrl #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int SHIFT_HZ = 5_000_000,
  parameter int SLOT_US  = 2000,
  parameter int CHARS    = 4,
  parameter int ROWS     = 7,
  parameter int COLS     = 5,
  parameter int PWM_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [$clog2(COLS)-1:0]        wr_col,
  input  logic [CHARS*ROWS-1:0]          wr_rows,
  input  logic [PWM_W-1:0]               bright,
  output logic                           ser_data,
  output logic                           ser_clk,
  output logic [COLS-1:0]                col_en
);

  import dmx_pkg::*;

  localparam int WORD_W     = CHARS * ROWS;
  localparam int COL_AW     = $clog2(COLS);
  localparam int HALF       = int'(shift_half_clks(CLK_HZ, SHIFT_HZ));
  localparam int SLOT_CLKS  = int'(slot_len_clks(CLK_HZ, SLOT_US));
  localparam int SHIFT_CLKS = WORD_W * 2 * HALF;
  localparam int ON_START   = 2 + SHIFT_CLKS;
  localparam int SLOT_W     = $clog2(SLOT_CLKS + 1);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CLKS - 1);
  localparam logic [SLOT_W-1:0] ON_FIRST  = SLOT_W'(ON_START);
  localparam logic [SLOT_W-1:0] ON_PREP   = SLOT_W'(ON_START - 1);
  localparam logic [COL_AW-1:0] COL_LAST  = COL_AW'(COLS - 1);

  // Slot sequencer
  logic [SLOT_W-1:0] slot_cnt;
  logic [COL_AW-1:0] col_idx;
  slot_phase_e       phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt <= '0;
      col_idx  <= '0;
    end else if (slot_cnt == SLOT_LAST) begin
      slot_cnt <= '0;
      col_idx  <= (col_idx == COL_LAST) ? '0 : col_idx + 1'b1;
    end else begin
      slot_cnt <= slot_cnt + 1'b1;
    end
  end

  always_comb begin
    if (slot_cnt == '0) begin
      phase = PH_FETCH;
    end else if (slot_cnt == SLOT_W'(1)) begin
      phase = PH_LOAD;
    end else if (slot_cnt < ON_FIRST) begin
      phase = PH_SHIFT;
    end else begin
      phase = PH_ON;
    end
  end

  // Frame RAM: read once per slot, at the fetch cycle
  logic [WORD_W-1:0] col_word;

  dmx_frame_mem #(
    .DEPTH (COLS),
    .WIDTH (WORD_W),
    .ADDR_W(COL_AW)
  ) u_mem (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_col),
    .wdata(wr_rows),
    .re   (phase == PH_FETCH),
    .raddr(col_idx),
    .rdata(col_word)
  );

  // Serializer
  logic shift_busy;

  dmx_row_shifter #(
    .WIDTH(WORD_W),
    .HALF (HALF)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (phase == PH_LOAD),
    .word    (col_word),
    .ser_data(ser_data),
    .ser_clk (ser_clk),
    .busy    (shift_busy)
  );

  // Brightness sampled once per slot
  logic [PWM_W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
    end else if (phase == PH_FETCH) begin
      level_q <= bright;
    end
  end

  logic pwm_on;

  dmx_pwm_gate #(
    .PW(PWM_W)
  ) u_pwm (
    .clk    (clk),
    .rst    (rst),
    .restart(slot_cnt == ON_PREP),
    .level  (level_q),
    .gate   (pwm_on)
  );

  // Column decode
  logic [COLS-1:0] col_onehot;

  for (genvar k = 0; k < COLS; k++) begin : g_dec
    assign col_onehot[k] = (col_idx == COL_AW'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_en <= '0;
    end else if ((phase == PH_ON) && !shift_busy && pwm_on) begin
      col_en <= col_onehot;
    end else begin
      col_en <= '0;
    end
  end

endmodule

// File: rtl/dmx_scan_chk.sv
module dmx_scan_chk #(
  parameter int COLS = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            ser_data,
  input logic            ser_clk,
  input logic [COLS-1:0] col_en
);

  AST_ONE_COLUMN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_en)); // R4

  AST_DARK_WHILE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> (col_en == '0)); // R5

  AST_DATA_SETTLED: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_data)); // R7

  AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_data) |-> !ser_clk); // R7

  AST_COLUMN_STEADY: assert property (@(posedge clk) disable iff (rst)
    ((col_en != '0) && ($past(col_en) != '0)) |-> (col_en == $past(col_en))); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> ((col_en == '0) && !ser_clk && !ser_data)); // R1

endmodule

bind dmx_scan_ctrl dmx_scan_chk #(.COLS(COLS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ser_data(ser_data),
  .ser_clk (ser_clk),
  .col_en  (col_en)
);

// File: tb/dmx_scan_ctrl_test.sv
module dmx_scan_ctrl_test;

  localparam int CLK_HZ   = 125_000_000;
  localparam int SHIFT_HZ = 5_000_000;
  localparam int SLOT_US  = 8;
  localparam int NCOL     = 5;
  localparam int NBITS    = 28;
  localparam int HALF     = (CLK_HZ + 2 * SHIFT_HZ - 1) / (2 * SHIFT_HZ);
  localparam int SLOT     = (CLK_HZ / 1000) * SLOT_US / 1000;
  localparam int ON_LEN   = SLOT - 2 - NBITS * 2 * HALF;
  localparam int NSLOT    = 40;
  localparam int LIMIT    = 60000;
  localparam logic [NBITS-1:0] MASK = '1;

  logic             clk = 1'b0;
  logic             rst;
  logic             wr_en;
  logic [2:0]       wr_col;
  logic [NBITS-1:0] wr_rows;
  logic [7:0]       bright;
  logic             ser_data;
  logic             ser_clk;
  logic [NCOL-1:0]  col_en;

  always #4 clk = ~clk;

  dmx_scan_ctrl #(
    .CLK_HZ  (CLK_HZ),
    .SHIFT_HZ(SHIFT_HZ),
    .SLOT_US (SLOT_US)
  ) uut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_col  (wr_col),
    .wr_rows (wr_rows),
    .bright  (bright),
    .ser_data(ser_data),
    .ser_clk (ser_clk),
    .col_en  (col_en)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_on(input int b);
    int rem;
    rem = ON_LEN % 256;
    if (b == 255) return ON_LEN;
    return (ON_LEN / 256) * b + ((rem < b) ? rem : b);
  endfunction

  int dir_b [8] = '{0, 255, 1, 14, 15, 128, 254, 200};

  logic [NBITS-1:0] shadow [NCOL];

  initial begin
    int cyc, slots, bits, cur_col, last_col, on_cnt, slot_start;
    int sclk_run, data_run, slot_b, prev_b;
    bit prev_sclk, prev_data, have_slot, tear, wrote;
    bit f_col, f_hot, f_dark, f_tim, f_dat, changed;
    logic [NBITS-1:0] word, snap;

    void'($urandom(32'd4242));
    rst = 1'b1; wr_en = 1'b0; wr_col = '0; wr_rows = '0; bright = 8'(dir_b[0]);
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCOL; c++) begin
      shadow[c] = MASK & NBITS'($urandom);
      wr_en = 1'b1; wr_col = 3'(c); wr_rows = shadow[c];
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);
    // R1: quiet outputs in reset
    chk(col_en == '0, "R1", "col_en in reset", col_en, 0);
    chk(!ser_clk, "R1", "ser_clk in reset", ser_clk, 0);
    chk(!ser_data, "R1", "ser_data in reset", ser_data, 0);
    rst = 1'b0;

    cyc = 0; slots = 0; bits = 0; cur_col = 0; last_col = 0; on_cnt = 0;
    slot_start = 0; sclk_run = 1; data_run = 1; slot_b = 0; prev_b = 0;
    prev_sclk = 0; prev_data = 0; have_slot = 0; tear = 0; changed = 0;
    f_col = 0; f_hot = 0; f_dark = 0; f_tim = 0; f_dat = 0;
    word = '0; snap = '0;

    while (slots <= NSLOT && cyc < LIMIT) begin
      @(negedge clk);
      wr_en = 1'b0;
      wrote = 1'b0;
      cyc++;

      if (ser_clk && col_en != '0) f_dark = 1'b1;
      if ($countones(col_en) > 1) f_hot = 1'b1;
      if (col_en != '0) begin
        on_cnt++;
        if (col_en != NCOL'(1 << last_col)) f_col = 1'b1;
      end
      if (ser_clk && (ser_data != prev_data)) f_dat = 1'b1;

      if (ser_clk && !prev_sclk) begin
        if (ser_data != prev_data || data_run < HALF) f_dat = 1'b1;
        if (bits == 0) begin
          if (!have_slot) begin
            chk(cyc == HALF + 2, "R8", "first shift edge after reset", cyc, HALF + 2);
          end else begin
            chk(cyc - slot_start == SLOT, "R8", "slot length", cyc - slot_start, SLOT);
            chk(!f_col, "R3", "column order/enable index", f_col, 0);
            chk(!f_hot, "R4", "multiple enables", f_hot, 0);
            chk(!f_dark, "R5", "enable during shift", f_dark, 0);
            chk(!f_tim, "R6", "shift clock half period", f_tim, 0);
            chk(!f_dat, "R7", "data settle/stability", f_dat, 0);
            if (slot_b == 0)
              chk(on_cnt == 0, "R11", "dark slot on-count", on_cnt, 0);
            else if (slot_b == 255)
              chk(on_cnt == ON_LEN, "R10", "full level on-count", on_cnt, ON_LEN);
            else
              chk(on_cnt == exp_on(slot_b), "R9", "pwm on-count", on_cnt, exp_on(slot_b));
            if (changed)
              chk(on_cnt == exp_on(slot_b), "R13", "level change after latch", on_cnt,
                  exp_on(slot_b));
            slots++;
          end
          have_slot = 1'b1;
          f_col = 0; f_hot = 0; f_dark = 0; f_tim = 0; f_dat = 0;
          slot_start = cyc;
          snap = shadow[cur_col];
          prev_b = slot_b;
          slot_b = int'(bright);
          bright = (slots + 1 < 8) ? 8'(dir_b[slots + 1]) : 8'($urandom);
          changed = (int'(bright) != slot_b);
          tear = 1'b0;
          if (slots == 6 || slots == 17) begin
            tear = 1'b1;
            shadow[cur_col] = MASK & ~snap;
            wr_en = 1'b1; wr_col = 3'(cur_col); wr_rows = shadow[cur_col];
            wrote = 1'b1;
          end
        end else begin
          if (sclk_run != HALF) f_tim = 1'b1;
        end
        word = {word[NBITS-2:0], ser_data};
        bits++;
      end

      if (!ser_clk && prev_sclk) begin
        if (sclk_run != HALF) f_tim = 1'b1;
        if (bits == NBITS) begin
          if (tear)
            chk(word == snap, "R12", "write during own shift", word, snap);
          else
            chk(word == snap, "R2", "shifted column word", word, snap);
          last_col = cur_col;
          cur_col = (cur_col + 1) % NCOL;
          bits = 0;
          on_cnt = 0;
        end
      end

      if (!wrote && ser_clk && bits > 0 && ($urandom % 6) == 0) begin
        int tc;
        tc = (cur_col + 1 + int'($urandom % 4)) % NCOL;
        shadow[tc] = MASK & NBITS'($urandom);
        wr_en = 1'b1; wr_col = 3'(tc); wr_rows = shadow[tc];
      end

      sclk_run  = (ser_clk != prev_sclk) ? 1 : sclk_run + 1;
      data_run  = (ser_data != prev_data) ? 1 : data_run + 1;
      prev_sclk = ser_clk;
      prev_data = ser_data;
    end

    if (cyc >= LIMIT) chk(1'b0, "R8", "watchdog expired", cyc, LIMIT);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule